// File: doc/BRIEF.md
# Protected Page Translation Buffer

This block turns a 32-bit virtual byte address into a physical address through a small cache of page mappings searched all at once. The upper 20 bits of the address are the virtual page number and the lower 12 bits are the offset inside a 4 KB page. Each of the 32 slots holds one mapping. A slot stores the virtual page it covers, the physical frame, a present flag, a two-bit rights code, and the dirty and referenced flags that the block keeps itself. A request also carries an access kind: read, write or instruction fetch.

The response is combinational in the cycle of the request. It reports exactly one outcome: a translation, a miss, a page fault or a protection fault. A translated access marks its slot as referenced, and a write also marks it dirty. These flag updates take effect at the clock edge that ends the request cycle.

After a miss, the surrounding logic fetches the mapping and loads it through the fill port into the slot chosen by a rotating pointer. A flush input empties the whole buffer in one cycle.

Top module: `page_xlat_buf`

## Requirements
- R1: A translated access returns `rsp_paddr` made of the stored 20-bit frame number in bits 31:12 and the request's own offset bits 11:0, unchanged.
- R2: All 32 slots are searched in parallel, and a mapping loaded into any of them translates.
- R3: When no occupied slot holds the requested page, `rsp_miss` is 1 and `rsp_paddr` is 0.
- R4: When the matching slot was loaded with its present flag clear, the access raises `rsp_page_fault` and returns no address.
- R5: Kind encoding is read=0, write=1, fetch=2. Rights encoding is 0 read-only (allows read), 1 read/write (allows read and write), 2 execute-only (allows fetch). A disallowed kind on a present page raises `rsp_prot_fault` with `rsp_paddr` 0. A page fault takes precedence over a protection fault.
- R6: On a translation, `rsp_ref` shows the slot's referenced flag as stored before this access, and the flag is 1 from the next cycle on. A fill stores the flag as 0.
- R7: A translated write sets the slot's dirty flag, which `rsp_dirty` shows on later translations. A read does not set it. A faulting access changes neither flag.
- R8: Each accepted fill writes the slot under a rotating pointer and advances it by one, wrapping after the last slot. The 33rd fill therefore replaces the first mapping of a run of 32.
- R9: A flush empties every slot at one clock edge. A fill presented in the same cycle as a flush is dropped.
- R10: A request and a fill in the same cycle see the slot contents from before the fill. When both touch one slot, the filled mapping and its cleared flags are what remain.
- R11: With `req_valid` low, every response output is 0 and no slot flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual byte address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| fill_valid | input | 1 | Load a mapping into the victim slot |
| fill_vpn | input | 20 | Virtual page number of the new mapping |
| fill_pfn | input | 20 | Physical frame number of the new mapping |
| fill_rights | input | 2 | Rights code: 0 read-only, 1 read/write, 2 execute-only |
| fill_present | input | 1 | Page is resident in memory |
| flush | input | 1 | Empty all slots |
| rsp_hit | output | 1 | Access translated |
| rsp_miss | output | 1 | No slot holds the page |
| rsp_page_fault | output | 1 | Matching mapping is not resident |
| rsp_prot_fault | output | 1 | Access kind not allowed by the rights |
| rsp_paddr | output | 32 | Physical address, 0 unless translated |
| rsp_dirty | output | 1 | Stored dirty flag of the translated slot |
| rsp_ref | output | 1 | Stored referenced flag of the translated slot |

## Verification
A translation and a fill can land in the same cycle, and with the victim pointer on the slot being read, the flag update and the new mapping compete for the same storage. The bench fills a full round of slots plus one more to put the pointer on a known slot. It then issues a write to that slot's page while filling a different page. The response must still carry the old frame, and later lookups must show the old page gone and the new page present with both flags clear.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        PERM_RO = 2'd0,
        PERM_RW = 2'd1,
        PERM_XO = 2'd2
    } perm_e;

endpackage

// File: rtl/pxb_match.sv
module pxb_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0]            occ,
    input  logic [VPN_W-1:0]              vpn,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign eq[i] = occ[i] && (tags[i] == vpn);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

    assign any = |eq;
endmodule

// File: rtl/pxb_rights.sv
module pxb_rights
    import pxb_pkg::*;
(
    input  logic [1:0] kind,
    input  logic [1:0] rights,
    output logic       allow
);
    always_comb begin
        unique case (perm_e'(rights))
            PERM_RO: allow = (acc_kind_e'(kind) == ACC_READ);
            PERM_RW: allow = (acc_kind_e'(kind) == ACC_READ) || (acc_kind_e'(kind) == ACC_WRITE);
            PERM_XO: allow = (acc_kind_e'(kind) == ACC_FETCH);
            default: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/pxb_victim.sv
module pxb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) begin
            ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/page_xlat_buf.sv
module page_xlat_buf
    import pxb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 32,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PFN_W    = PA_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_rights,
    input  logic             fill_present,
    input  logic             flush,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_page_fault,
    output logic             rsp_prot_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_dirty,
    output logic             rsp_ref
);
    typedef struct packed {
        logic             occ;
        logic             present;
        logic             dirty;
        logic             refd;
        logic [1:0]       rights;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } state_t;

    state_t state_d, state_q;

    logic [ENTRIES-1:0][VPN_W-1:0] tags;
    logic [ENTRIES-1:0]            occ;
    logic                          match_any;
    logic [IDX_W-1:0]              match_idx;
    logic                          allow;
    logic [IDX_W-1:0]              victim;
    slot_t                         sel;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_tag
        assign tags[i] = state_q.slot[i].vpn;
        assign occ[i]  = state_q.slot[i].occ;
    end

    pxb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .tags (tags),
        .occ  (occ),
        .vpn  (req_vaddr[VA_W-1:PAGE_BITS]),
        .any  (match_any),
        .idx  (match_idx)
    );

    assign sel = state_q.slot[match_idx];

    pxb_rights u_rights (
        .kind   (req_kind),
        .rights (sel.rights),
        .allow  (allow)
    );

    pxb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fill_valid && !flush),
        .ptr     (victim)
    );

    // Outcome decode: page fault outranks protection, protection outranks hit
    always_comb begin
        rsp_miss       = req_valid && !match_any;
        rsp_page_fault = req_valid && match_any && !sel.present;
        rsp_prot_fault = req_valid && match_any && sel.present && !allow;
        rsp_hit        = req_valid && match_any && sel.present && allow;
        rsp_paddr      = rsp_hit ? {sel.pfn, req_vaddr[PAGE_BITS-1:0]} : '0;
        rsp_dirty      = rsp_hit && sel.dirty;
        rsp_ref        = rsp_hit && sel.refd;
    end

    // Next state: flag update, then fill, then flush (later steps win)
    always_comb begin
        state_d = state_q;
        if (rsp_hit) begin
            state_d.slot[match_idx].refd = 1'b1;
            if (acc_kind_e'(req_kind) == ACC_WRITE) begin
                state_d.slot[match_idx].dirty = 1'b1;
            end
        end
        if (fill_valid) begin
            state_d.slot[victim].occ     = 1'b1;
            state_d.slot[victim].present = fill_present;
            state_d.slot[victim].dirty   = 1'b0;
            state_d.slot[victim].refd    = 1'b0;
            state_d.slot[victim].rights  = fill_rights;
            state_d.slot[victim].vpn     = fill_vpn;
            state_d.slot[victim].pfn     = fill_pfn;
        end
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                state_d.slot[i].occ = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/pxb_checker.sv
module pxb_checker #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            fill_valid,
    input logic            flush,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_page_fault,
    input logic            rsp_prot_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_dirty,
    input logic            rsp_ref
);
    // R5
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault}));

    // R1
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[PAGE_BITS-1:0] == req_vaddr[PAGE_BITS-1:0]));

    // R3
    miss_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0));

    // R5
    prot_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_prot_fault || rsp_page_fault) |-> (rsp_paddr == '0));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !(rsp_hit || rsp_page_fault || rsp_prot_fault));

    // R6
    ref_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !flush && !fill_valid) |=>
            (!(req_valid && $stable(req_vaddr) && rsp_hit) || rsp_ref));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(rsp_hit || rsp_miss || rsp_page_fault || rsp_prot_fault
                         || rsp_dirty || rsp_ref || (rsp_paddr != '0)));
endmodule

bind page_xlat_buf pxb_checker #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
) u_pxb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .fill_valid     (fill_valid),
    .flush          (flush),
    .rsp_hit        (rsp_hit),
    .rsp_miss       (rsp_miss),
    .rsp_page_fault (rsp_page_fault),
    .rsp_prot_fault (rsp_prot_fault),
    .rsp_paddr      (rsp_paddr),
    .rsp_dirty      (rsp_dirty),
    .rsp_ref        (rsp_ref)
);

// File: tb/tb_page_xlat_buf.sv
module tb_page_xlat_buf;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_pfn;
    logic [1:0]  fill_rights;
    logic        fill_present;
    logic        flush;
    logic        rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault;
    logic [31:0] rsp_paddr;
    logic        rsp_dirty, rsp_ref;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0]  got;   // {hit, miss, pf, prot, dirty, ref, any_addr}
    logic [31:0] got_pa;

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_FE = 2'd2;
    localparam logic [1:0] P_RO = 2'd0, P_RW = 2'd1, P_XO = 2'd2;

    always #5 clk = ~clk;

    page_xlat_buf dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_rights(fill_rights), .fill_present(fill_present),
        .flush(flush), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
        .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // outcome codes for check of {hit,miss,pf,prot}
    localparam logic [31:0] O_HIT = 32'b1000, O_MISS = 32'b0100, O_PF = 32'b0010, O_PROT = 32'b0001;

    task automatic sample();
        got    = {rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault, rsp_dirty, rsp_ref, |rsp_paddr};
        got_pa = rsp_paddr;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] kind);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        #2 sample();
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [1:0] rights, input logic present);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
        fill_rights = rights; fill_present = present;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    task automatic do_flush(input logic with_fill, input logic [19:0] vpn);
        @(negedge clk);
        flush = 1'b1; fill_valid = with_fill; fill_vpn = vpn; fill_pfn = 20'h1;
        fill_rights = P_RW; fill_present = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0; fill_valid = 1'b0;
    endtask

    function automatic logic [31:0] outc();
        return {28'd0, got[6:3]};
    endfunction

    task automatic t_reset();
        lookup(32'h1234_5678, K_RD);
        check("R3 miss after reset", outc(), O_MISS);
        check("R3 no address on miss", got_pa, 32'h0);
    endtask

    task automatic t_basic();
        fill(20'h12345, 20'hABCDE, P_RW, 1'b1);
        lookup(32'h1234_5678, K_RD);
        check("R1 hit", outc(), O_HIT);
        check("R1 paddr concat", got_pa, 32'hABCD_E678);
        check("R6 ref clear on first hit", {31'd0, got[1]}, 32'd0);
        lookup(32'h1234_5FFF, K_RD);
        check("R1 paddr offset FFF", got_pa, 32'hABCD_EFFF);
        check("R6 ref set after hit", {31'd0, got[1]}, 32'd1);
        check("R7 read leaves dirty clear", {31'd0, got[2]}, 32'd0);
        lookup(32'h1234_6000, K_RD);
        check("R3 neighbour page misses", outc(), O_MISS);
    endtask

    task automatic t_rights();
        fill(20'h00020, 20'h00055, P_RO, 1'b1);
        lookup(32'h0002_0010, K_WR);
        check("R5 write on read-only faults", outc(), O_PROT);
        check("R5 no address on prot fault", got_pa, 32'h0);
        lookup(32'h0002_0010, K_FE);
        check("R5 fetch on read-only faults", outc(), O_PROT);
        lookup(32'h0002_0010, K_RD);
        check("R5 read on read-only hits", outc(), O_HIT);
        check("R7 faulting accesses left flags clear", {30'd0, got[2:1]}, 32'd0);
        fill(20'h00030, 20'h00066, P_XO, 1'b1);
        lookup(32'h0003_0004, K_RD);
        check("R5 read on execute-only faults", outc(), O_PROT);
        lookup(32'h0003_0004, K_FE);
        check("R5 fetch on execute-only hits", outc(), O_HIT);
        check("R5 fetch paddr", got_pa, 32'h0006_6004);
        fill(20'h00040, 20'h00077, P_RW, 1'b1);
        lookup(32'h0004_0000, K_FE);
        check("R5 fetch on read/write faults", outc(), O_PROT);
        lookup(32'h0004_0008, K_WR);
        check("R7 write hits", outc(), O_HIT);
        check("R7 dirty clear before first write", {31'd0, got[2]}, 32'd0);
        lookup(32'h0004_0008, K_RD);
        check("R7 dirty set after write", {31'd0, got[2]}, 32'd1);
    endtask

    task automatic t_pagefault();
        fill(20'h00050, 20'h00088, P_RO, 1'b0);
        lookup(32'h0005_0000, K_RD);
        check("R4 non-resident read faults", outc(), O_PF);
        check("R4 no address", got_pa, 32'h0);
        lookup(32'h0005_0000, K_WR);
        check("R5 page fault precedes protection", outc(), O_PF);
    endtask

    task automatic t_idle();
        fill(20'h00060, 20'h00099, P_RW, 1'b1);
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = 32'h0006_0000; req_kind = K_WR;
        #2 sample();
        check("R11 idle outputs zero", {25'd0, got}, 32'd0);
        @(posedge clk); #1;
        lookup(32'h0006_0000, K_RD);
        check("R11 idle left flags clear", {30'd0, got[2:1]}, 32'd0);
    endtask

    task automatic t_flush();
        do_flush(1'b0, 20'h0);
        lookup(32'h1234_5678, K_RD);
        check("R9 flush empties buffer", outc(), O_MISS);
        lookup(32'h0004_0008, K_RD);
        check("R9 flush empties second page", outc(), O_MISS);
        do_flush(1'b1, 20'h00070);
        lookup(32'h0007_0000, K_RD);
        check("R9 fill dropped under flush", outc(), O_MISS);
    endtask

    task automatic t_rr();
        int hits = 0;
        for (int i = 0; i < 32; i++) fill(20'h00300 + 20'(i), 20'h40000 + 20'(i), P_RW, 1'b1);
        for (int i = 0; i < 32; i++) begin
            lookup({20'h00300 + 20'(i), 12'h004}, K_RD);
            if (got[6] && got_pa == {20'h40000 + 20'(i), 12'h004}) hits++;
        end
        check("R2 all 32 slots translate", 32'(hits), 32'd32);
        fill(20'h00999, 20'h0BEEF, P_RW, 1'b1);
        lookup(32'h0030_0000, K_RD);
        check("R8 oldest mapping replaced", outc(), O_MISS);
        lookup(32'h0030_1000, K_RD);
        check("R8 next mapping kept", outc(), O_HIT);
        lookup(32'h0099_9ABC, K_RD);
        check("R8 new mapping translates", got_pa, 32'h0BEE_FABC);
    endtask

    task automatic t_concurrent();
        // victim pointer now sits on the slot holding page 0x00301
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0030_1010; req_kind = K_WR;
        fill_valid = 1'b1; fill_vpn = 20'h00777; fill_pfn = 20'h0CAFE;
        fill_rights = P_RW; fill_present = 1'b1;
        #2 sample();
        check("R10 lookup sees old slot", got_pa, 32'h4000_1010);
        @(posedge clk); #1;
        req_valid = 1'b0; fill_valid = 1'b0;
        lookup(32'h0030_1010, K_RD);
        check("R10 old page replaced", outc(), O_MISS);
        lookup(32'h0077_7020, K_RD);
        check("R10 filled page translates", got_pa, 32'h0CAF_E020);
        check("R10 filled flags clear", {30'd0, got[2:1]}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_rights = '0;
        fill_present = 1'b0; flush = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_rights();
        t_pagefault();
        t_idle();
        t_flush();
        t_rr();
        t_concurrent();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule